// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block sits between a processor core and its interrupt sources. It takes a set of level-sensitive maskable request lines from on-chip peripherals and one active-low non-maskable pin. From these it raises a single request line to the core. Each maskable line is gated by its own enable bit and by the global enable bit from the processor status word. The non-maskable pin is synchronized and acts on a falling edge. A detected edge stays pending until the core services it.

When the core acknowledges, the block loads the dispatch-table index of the winning request into a vector register. The core reads that register to find its service routine. The register then keeps its value until the next acknowledge. The non-maskable request uses a fixed low slot. Maskable source n uses the slot at a base offset plus n.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq` is low and `vector` reads 0.
- R2: A maskable source n whose request and enable are both high, while `gie` is high, drives `irq` high one clock later. An acknowledge then loads `vector` with 16 + n (source 0 gives 16, source 21 gives 37).
- R3: A maskable request whose enable bit is low is ignored: `irq` stays low and an acknowledge loads 0.
- R4: While `gie` is low, no maskable request raises `irq`.
- R5: When several enabled maskable sources request at once, the lowest-numbered one is reported.
- R6: A falling edge on `nmi_n` passes through a two-flop synchronizer. `irq` rises on the third rising clock edge after the low level is first set up, and an acknowledge then loads `vector` with 1.
- R7: A low level held on `nmi_n` after its request was acknowledged raises no new request. Only a fresh high-to-low transition does.
- R8: A pending non-maskable request wins over any pending maskable request and is not blocked by `gie`.
- R9: `vector` changes only on a cycle with `ack` high. A request that arrives later, even one of higher priority, leaves `vector` unchanged until the next acknowledge.
- R10: With nothing pending, `irq` is low and an acknowledge loads `vector` with 0.
- R11: A pending non-maskable request is cleared only by the acknowledge that delivers its vector. A maskable request still pending at that point is reported by the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 22 | Level request from each maskable source |
| src_en | input | 22 | Per-source enable bits |
| gie | input | 1 | Global maskable-interrupt enable from the status word |
| nmi_n | input | 1 | Active-low non-maskable pin, falling-edge sensitive |
| ack | input | 1 | One-cycle acknowledge from the core |
| irq | output | 1 | Registered interrupt request to the core |
| vector | output | 6 | Dispatch index latched at the last acknowledge |

## Verification
The bench builds the block with its default parameters: 22 maskable sources, a slot base of 16, the non-maskable slot at 1 and two synchronizer stages. These values make the top slot, 37, reachable, and 37 needs every bit of the 6-bit vector. The two-stage synchronizer fixes the latency of the non-maskable path to three edges, and the bench checks that latency exactly. Random mixes of requests, enables and the global enable are drawn with a bias toward sparse request sets, so that the lowest-number rule is exercised across the whole range.

// File: rtl/irq_pkg.sv
package irq_pkg;
    parameter int unsigned DEF_NUM_SRC   = 22;
    parameter int unsigned DEF_MASK_BASE = 16;
    parameter int unsigned DEF_NMI_SLOT  = 1;
    parameter int unsigned DEF_SYNC_LEN  = 2;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_NMI  = 2'd1,
        WIN_MASK = 2'd2
    } win_kind_e;
endpackage

// File: rtl/irq_nmi_sync.sv
module irq_nmi_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_q, s_d;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], pin_n};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign fall = s_q.prev & ~s_q.chain[STAGES-1];

    // R7: an edge is reported for one cycle only
    p_edge_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int unsigned N     = 22,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = i[IDX_W-1:0];
        end
        hit = |req;
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned NUM_SRC   = DEF_NUM_SRC,
    parameter int unsigned MASK_BASE = DEF_MASK_BASE,
    parameter int unsigned NMI_SLOT  = DEF_NMI_SLOT,
    parameter int unsigned SYNC_LEN  = DEF_SYNC_LEN,
    parameter int unsigned VEC_W     = $clog2(MASK_BASE + NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               gie,
    input  logic               nmi_n,
    input  logic               ack,
    output logic               irq,
    output logic [VEC_W-1:0]   vector
);
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [VEC_W-1:0] BASE_V = VEC_W'(MASK_BASE);
    localparam logic [VEC_W-1:0] NMI_V  = VEC_W'(NMI_SLOT);

    typedef struct packed {
        logic             nmi_pend;
        logic             irq;
        logic [VEC_W-1:0] vector;
    } state_t;

    state_t            cur_q, cur_d;
    logic              nmi_fall;
    logic [NUM_SRC-1:0] live;
    logic              hit;
    logic [IDX_W-1:0]  idx;
    win_kind_e         win;
    logic [VEC_W-1:0]  win_vec;

    irq_nmi_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (nmi_n),
        .fall  (nmi_fall)
    );

    assign live = src_req & src_en & {NUM_SRC{gie}};

    irq_lowest_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .req (live),
        .hit (hit),
        .idx (idx)
    );

    always_comb begin
        if (cur_q.nmi_pend) win = WIN_NMI;
        else if (hit)       win = WIN_MASK;
        else                win = WIN_NONE;

        unique case (win)
            WIN_NMI:  win_vec = NMI_V;
            WIN_MASK: win_vec = BASE_V + VEC_W'(idx);
            default:  win_vec = '0;
        endcase

        cur_d = cur_q;
        if (ack && win == WIN_NMI) cur_d.nmi_pend = 1'b0;
        if (nmi_fall)              cur_d.nmi_pend = 1'b1;
        if (ack)                   cur_d.vector   = win_vec;
        cur_d.irq = cur_d.nmi_pend | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign irq    = cur_q.irq;
    assign vector = cur_q.vector;

    p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> $stable(vector));

    p_nmi_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && cur_q.nmi_pend) |=> vector == NMI_V);

    p_nmi_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && cur_q.nmi_pend && !nmi_fall) |=> !cur_q.nmi_pend);

    p_gie_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie && !cur_q.nmi_pend && !nmi_fall) |=> !irq);

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !cur_q.nmi_pend && live == '0) |=> vector == '0);

    p_vec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vector == '0 || vector == NMI_V ||
        (vector >= BASE_V && vector < BASE_V + VEC_W'(NUM_SRC)));
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
    localparam int N = 22;
    localparam int VW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_req = '0;
    logic [N-1:0]  src_en = '0;
    logic          gie = 1'b0;
    logic          nmi_n = 1'b1;
    logic          ack = 1'b0;
    logic          irq;
    logic [VW-1:0] vector;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
        .gie(gie), .nmi_n(nmi_n), .ack(ack), .irq(irq), .vector(vector)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int exp_vec(input logic [N-1:0] r, input logic [N-1:0] e, input logic g);
        for (int i = 0; i < N; i++)
            if (r[i] && e[i] && g) return 16 + i;
        return 0;
    endfunction

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_ack();
        ack = 1'b1;
        step();
        ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [31:0] t;
        void'($urandom(32'd20240611));
        step(3);
        chk(irq == 1'b0, "R1 irq", int'(irq), 0);
        chk(vector == '0, "R1 vector", int'(vector), 0);
        rst_n = 1'b1;
        step();

        // R10: idle acknowledge
        do_ack();
        chk(irq == 1'b0, "R10 irq", int'(irq), 0);
        chk(vector == '0, "R10 vector", int'(vector), 0);

        // R2: top source reaches slot 37
        gie = 1'b1; src_en = '1; src_req = '0; src_req[21] = 1'b1;
        step();
        chk(irq == 1'b1, "R2 irq", int'(irq), 1);
        do_ack();
        chk(vector == 6'd37, "R2 vector", int'(vector), 37);

        // R3: disabled source ignored
        src_en[21] = 1'b0;
        step();
        chk(irq == 1'b0, "R3 irq", int'(irq), 0);
        do_ack();
        chk(vector == '0, "R3 vector", int'(vector), 0);

        // R4: global enable blocks
        src_en = '1; src_req = 22'h3FFFFF; gie = 1'b0;
        step(2);
        chk(irq == 1'b0, "R4 irq", int'(irq), 0);

        // R5: lowest wins
        gie = 1'b1; src_req = '0; src_req[3] = 1'b1; src_req[9] = 1'b1; src_req[20] = 1'b1;
        step();
        do_ack();
        chk(vector == 6'd19, "R5 vector", int'(vector), 19);

        // R9: vector holds against later higher-priority request
        src_req = '0; src_req[5] = 1'b1;
        step();
        do_ack();
        chk(vector == 6'd21, "R9 first", int'(vector), 21);
        src_req[0] = 1'b1;
        step(4);
        chk(vector == 6'd21, "R9 hold", int'(vector), 21);
        do_ack();
        chk(vector == 6'd16, "R9 next", int'(vector), 16);

        // R6: non-maskable latency and slot
        src_req = '0;
        step();
        nmi_n = 1'b0;
        step(2);
        chk(irq == 1'b0, "R6 early", int'(irq), 0);
        step();
        chk(irq == 1'b1, "R6 irq", int'(irq), 1);
        do_ack();
        chk(vector == 6'd1, "R6 vector", int'(vector), 1);
        chk(irq == 1'b0, "R6 cleared", int'(irq), 0);

        // R7: held low does not retrigger
        step(6);
        chk(irq == 1'b0, "R7 level", int'(irq), 0);
        do_ack();
        chk(vector == '0, "R7 vector", int'(vector), 0);
        nmi_n = 1'b1;
        step(4);
        nmi_n = 1'b0;
        step(3);
        chk(irq == 1'b1, "R7 new edge", int'(irq), 1);

        // R8 + R11: NMI beats maskable with gie low, then maskable follows
        gie = 1'b0; src_req[2] = 1'b1;
        step();
        do_ack();
        chk(vector == 6'd1, "R8 vector", int'(vector), 1);
        chk(irq == 1'b0, "R11 gie low", int'(irq), 0);
        gie = 1'b1;
        step();
        chk(irq == 1'b1, "R11 irq", int'(irq), 1);
        do_ack();
        chk(vector == 6'd18, "R11 vector", int'(vector), 18);
        nmi_n = 1'b1; src_req = '0;
        step(4);

        // random: R2, R3, R4, R5, R10
        for (int k = 0; k < 300; k++) begin
            int ev;
            t = $urandom() & $urandom();
            if (k % 3 == 0) t = t & $urandom();
            src_req = t[N-1:0];
            t = $urandom() | $urandom();
            src_en = t[N-1:0];
            gie = ($urandom() % 4) != 0;
            ev = exp_vec(src_req, src_en, gie);
            step();
            chk(irq == (ev != 0), "R5 rnd irq", int'(irq), int'(ev != 0));
            do_ack();
            chk(int'(vector) == ev, "R5 rnd vector", int'(vector), ev);
        end
        finish_run();
    end
endmodule